// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external 32K x 8 asynchronous static RAM. The host issues one single-word read or write at a time through a request/ready handshake. The block turns each request into a sequence of chip-enable, output-enable and write-enable strobes. Each strobe phase is held for a whole number of system clock cycles. Read data comes back to the host with a one-cycle valid pulse.

The phase lengths are derived at elaboration time from the clock period and a speed-grade parameter. Grade 0 is the fast part: 40 ns write pulse, 25 ns data setup, 55 ns access. Grade 1 is the slow part: 50 ns pulse, 30 ns setup, 70 ns access. Both grades use a 30 ns output-off time.

Every write is controlled by the write-enable strobe. The address register changes only while the block is idle. The data drivers are switched on only after the memory's outputs have had time to float, so the controller and the memory never drive the bus at the same time. The data bus is split into an output, an output enable and an input; a pad cell outside the block joins them.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During reset and whenever idle, the memory is in standby: `sram_ce_no`, `sram_we_no` and `sram_oe_no` are all 1, `sram_dq_oe_o` is 0, and `ready_o` is 1.
- R2: `sram_addr_o` changes only in cycles where `sram_we_no` is 1 both before and after the change. Throughout a write pulse it equals the address the host requested.
- R3: A write pulse holds `sram_we_no` low, with `sram_ce_no` low, for WP = ceil(max(pulse, setup)/period) cycles. With the defaults this is 2 cycles. `sram_dq_oe_o` is 1 and the data is stable for the whole pulse and for one more cycle after `sram_we_no` rises.
- R4: Every write pulse is preceded by exactly TA = ceil(30 ns/period) cycles with `sram_ce_no` low, `sram_oe_no` high, `sram_we_no` high and the drivers off. With the defaults this is 2 cycles.
- R5: `sram_dq_oe_o` is never 1 while `sram_oe_no` is low, nor in the TA cycles that follow a read.
- R6: A read holds `sram_ce_no` and `sram_oe_no` low, with `sram_we_no` high, for RD = ceil(access/period) cycles. With the defaults this is 3 cycles. The bus is captured at the clock edge that ends the last of these cycles, and the captured word is the stored byte (0 for a location never written).
- R7: `rd_valid_o` is high for exactly one cycle per read, in the cycle after the capture. `rd_data_o` carries the captured word in that cycle.
- R8: A request is taken when `req_i` and `ready_o` are both 1 in the same cycle. `ready_o` then stays 0 for TA+WP+1 cycles after a write, or RD+TA cycles after a read. With the defaults both are 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Controller idle, request may be taken |
| rd_data_o | output | 8 | Read data |
| rd_valid_o | output | 1 | Read data valid pulse |
| sram_addr_o | output | 15 | Memory address |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_dq_o | output | 8 | Data driven to memory |
| sram_dq_oe_o | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 8 | Data returned from memory |

## Verification
The bench drives a mix of directed and seeded random requests:
- **Directed read-after-write:** writes at address 0 and 0x7FFF, each followed by a read, show that the full address width is used and that read-back is correct.
- **Unwritten location:** a read of a location never written separates a real capture from stale data held in the capture register.
- **Random mix:** alternating read/write traffic over a small address window causes frequent write-after-read turnarounds. It also gives read-back hits on recently written data.

A behavioural memory model in the bench watches the strobes:
- It returns unknown data until the access time has elapsed, so an early capture shows up as a miscompare.
- It flags bus contention during the output-off window.
- It flags short write pulses and short data setup.
- It flags any address change while write enable is low.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_TURN,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_R_ACCESS,
    ST_R_TURN
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned pulse_ns(input int unsigned grade);
    return (grade != 0) ? 50 : 40;
  endfunction

  function automatic int unsigned setup_ns(input int unsigned grade);
    return (grade != 0) ? 30 : 25;
  endfunction

  function automatic int unsigned access_ns(input int unsigned grade);
    return (grade != 0) ? 70 : 55;
  endfunction

  localparam int unsigned OFF_NS = 30;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_strobe_pkg::*;
#(
  parameter int unsigned TA    = 2,
  parameter int unsigned WP    = 2,
  parameter int unsigned RD    = 3,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             start_we_i,
  input  logic             phase_done_i,
  output seq_state_e       state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             capture_o
);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        if (start_we_i) begin
          state_d    = ST_W_TURN;
          load_val_o = TA_LD;
        end else begin
          state_d    = ST_R_ACCESS;
          load_val_o = RD_LD;
        end
      end
      ST_W_TURN: if (phase_done_i) begin
        state_d    = ST_W_PULSE;
        load_o     = 1'b1;
        load_val_o = WP_LD;
      end
      ST_W_PULSE: if (phase_done_i) begin
        state_d = ST_W_HOLD;
        load_o  = 1'b1;
      end
      ST_W_HOLD: if (phase_done_i) state_d = ST_IDLE;
      ST_R_ACCESS: if (phase_done_i) begin
        capture_o  = 1'b1;
        state_d    = ST_R_TURN;
        load_o     = 1'b1;
        load_val_o = TA_LD;
      end
      ST_R_TURN: if (phase_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= capture_i;
      if (capture_i) data_o <= dq_i;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_strobe_pkg::*;
#(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned SPEED_GRADE  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned TA_CYC = ns_to_cyc(OFF_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_NS  = (pulse_ns(SPEED_GRADE) > setup_ns(SPEED_GRADE)) ?
                                   pulse_ns(SPEED_GRADE) : setup_ns(SPEED_GRADE);
  localparam int unsigned WP_CYC = ns_to_cyc(WP_NS, CLK_PERIOD_NS);
  localparam int unsigned RD_CYC = ns_to_cyc(access_ns(SPEED_GRADE), CLK_PERIOD_NS);
  localparam int unsigned MAX_A  = (TA_CYC > WP_CYC) ? TA_CYC : WP_CYC;
  localparam int unsigned MAX_C  = (MAX_A > RD_CYC) ? MAX_A : RD_CYC;
  localparam int unsigned CNT_W  = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  seq_state_e       state;
  logic             start, load, done, capture;
  logic [CNT_W-1:0] load_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign ready_o = (state == ST_IDLE);
  assign start   = req_i & ready_o;

  // address and data latch only on acceptance, i.e. while write enable is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  sram_seq_fsm #(
    .TA(TA_CYC), .WP(WP_CYC), .RD(RD_CYC), .CNT_W(CNT_W)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_we_i  (req_we_i),
    .phase_done_i(done),
    .state_o     (state),
    .load_o      (load),
    .load_val_o  (load_val),
    .capture_o   (capture)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .done_o    (done)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .dq_i     (sram_dq_i),
    .data_o   (rd_data_o),
    .valid_o  (rd_valid_o)
  );

  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign sram_ce_no   = (state == ST_IDLE);
  assign sram_we_no   = (state != ST_W_PULSE);
  assign sram_oe_no   = (state != ST_R_ACCESS);
  assign sram_dq_oe_o = (state == ST_W_PULSE) || (state == ST_W_HOLD);
endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_ce_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic              sram_dq_oe_o
);
  p_idle_standby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no || !$past(sram_we_no)) |-> $stable(sram_addr_o));

  p_we_with_ce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_ce_no);

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o);

  p_pulse_driven_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_dq_oe_o);

  p_turn_before_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> ($past(!sram_ce_no) && $past(sram_oe_no) && !$past(sram_dq_oe_o)));

  p_no_contention_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_dq_oe_o && !sram_oe_no));

  p_turn_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> !sram_dq_oe_o);

  p_valid_after_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!sram_oe_no));

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o);
endmodule

bind sram_strobe_ctrl sram_strobe_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ready_o     (ready_o),
  .rd_valid_o  (rd_valid_o),
  .sram_addr_o (sram_addr_o),
  .sram_ce_no  (sram_ce_no),
  .sram_we_no  (sram_we_no),
  .sram_oe_no  (sram_oe_no),
  .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;
  localparam int P      = 20;
  localparam int T_WP   = 40;
  localparam int T_DW   = 25;
  localparam int T_ACC  = 55;
  localparam int T_OFF  = 30;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int TA_E = (T_OFF + P - 1) / P;
  localparam int WP_E = (((T_WP > T_DW) ? T_WP : T_DW) + P - 1) / P;
  localparam int RD_E = (T_ACC + P - 1) / P;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [14:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic        ready_o, rd_valid_o;
  logic [7:0]  rd_data_o;
  logic [14:0] sram_addr_o;
  logic        sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o;
  logic [7:0]  sram_dq_o, sram_dq_i;

  always #(P/2) clk_i = ~clk_i;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk_i, .rst_ni, .req_i, .req_we_i, .req_addr_i, .req_wdata_i,
    .ready_o, .rd_data_o, .rd_valid_o, .sram_addr_o, .sram_ce_no,
    .sram_we_no, .sram_oe_no, .sram_dq_o, .sram_dq_oe_o, .sram_dq_i
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done_f = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural memory and scoreboard
  logic [7:0] mem [int];
  logic [7:0] sb  [int];

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  logic mem_drive;
  int   acc_run = 0, hz_run = 1000, we_run = 0, dstab = 0, pre_run = 0;
  logic [14:0] prev_addr = '0, last_waddr = '0;
  logic        prev_we = 1'b1, have_prev = 1'b0;
  logic [7:0]  last_wdata = '0;

  assign mem_drive = !sram_ce_no && !sram_oe_no && sram_we_no;
  assign sram_dq_i = mem_drive ? (((acc_run + 1) * P >= T_ACC) ? mem_rd(sram_addr_o) : 8'hxx)
                               : 8'hzz;

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (have_prev && sram_addr_o != prev_addr && (!sram_we_no || !prev_we))
        chk(1'b0, "R2", "address moved near write pulse", int'(sram_addr_o), int'(prev_addr));
      prev_addr <= sram_addr_o;
      prev_we   <= sram_we_no;
      have_prev <= 1'b1;
      if (sram_dq_oe_o && (mem_drive || hz_run * P < T_OFF))
        chk(1'b0, "R5", "bus contention, off-cycles", hz_run, cyc(T_OFF));
      hz_run  <= mem_drive ? 0 : ((hz_run < 1000) ? hz_run + 1 : hz_run);
      acc_run <= mem_drive ? acc_run + 1 : 0;
      if (!sram_we_no) begin
        if (we_run == 0) chk(pre_run == TA_E, "R4", "turnaround cycles", pre_run, TA_E);
        if (!sram_dq_oe_o) chk(1'b0, "R3", "drivers off in pulse", 0, 1);
        dstab      <= (we_run > 0 && sram_dq_o == last_wdata) ? dstab + 1 : 1;
        we_run     <= we_run + 1;
        last_wdata <= sram_dq_o;
        last_waddr <= sram_addr_o;
      end else if (we_run > 0) begin
        chk(sram_dq_oe_o && sram_dq_o == last_wdata, "R3", "data hold after pulse",
            int'(sram_dq_o), int'(last_wdata));
        chk(we_run == WP_E && we_run * P >= T_WP, "R3", "write pulse cycles", we_run, WP_E);
        chk(dstab * P >= T_DW, "R3", "data setup cycles", dstab, cyc(T_DW));
        mem[int'(last_waddr)] = last_wdata;
        we_run <= 0;
      end
      pre_run <= (!sram_ce_no && sram_oe_no && sram_we_no && !sram_dq_oe_o) ? pre_run + 1 : 0;
    end
  end

  task automatic do_op(input bit we, input logic [14:0] a, input logic [7:0] d);
    int busy, vcyc, vlen;
    logic [7:0] exp_d, got_d;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d;
    exp_d = sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
    @(negedge clk_i);
    req_i = 1'b0;
    busy = 0; vcyc = 0; vlen = 0; got_d = '0;
    while (!ready_o && busy < 100) begin
      busy++;
      if (rd_valid_o) begin
        vlen++;
        if (vcyc == 0) begin vcyc = busy; got_d = rd_data_o; end
      end
      @(negedge clk_i);
    end
    if (rd_valid_o) vlen++;
    if (we) begin
      sb[int'(a)] = d;
      chk(busy == TA_E + WP_E + 1, "R8", "write busy cycles", busy, TA_E + WP_E + 1);
      chk(vlen == 0, "R7", "valid on write", vlen, 0);
    end else begin
      chk(busy == RD_E + TA_E, "R8", "read busy cycles", busy, RD_E + TA_E);
      chk(vcyc == RD_E + 1, "R6", "capture latency", vcyc, RD_E + 1);
      chk(got_d === exp_d, "R6", "read data", int'(got_d), int'(exp_d));
      chk(vlen == 1, "R7", "valid pulse length", vlen, 1);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(sram_ce_no && sram_we_no && sram_oe_no && !sram_dq_oe_o && ready_o,
        "R1", tag, {sram_ce_no, sram_we_no, sram_oe_no, sram_dq_oe_o, ready_o}, 5'b11101);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk_idle("outputs in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("outputs after reset");
    chk(rd_valid_o == 1'b0, "R7", "valid after reset", rd_valid_o, 0);

    do_op(1'b0, 15'h1234, 8'h00);     // unwritten location reads 0 (R6)
    do_op(1'b1, 15'h0000, 8'hA5);
    do_op(1'b0, 15'h0000, 8'h00);
    do_op(1'b1, 15'h7FFF, 8'h5A);
    do_op(1'b0, 15'h7FFF, 8'h00);
    do_op(1'b0, 15'h0000, 8'h00);
    do_op(1'b1, 15'h0001, 8'hFF);
    do_op(1'b1, 15'h0001, 8'h3C);     // overwrite, back to back
    do_op(1'b0, 15'h0001, 8'h00);
    @(negedge clk_i);
    chk_idle("standby between requests");

    for (int i = 0; i < 400; i++) begin
      logic [14:0] a;
      a = ($urandom_range(0, 3) == 0) ? 15'($urandom) : 15'($urandom_range(0, 31));
      do_op(1'($urandom_range(0, 1)), a, 8'($urandom));
    end
    @(negedge clk_i);
    chk_idle("standby at end");

    if (!done_f) begin
      done_f = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk_i); wd++; end
    if (!done_f) begin
      done_f = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule